// File: doc/BRIEF.md
# Keyed-Arming Watchdog Timer

A memory-mapped watchdog peripheral. An up-counter starts from a software-programmed load value and advances on a slow tick input, which stands in for a low-frequency functional clock. A programmable prescaler can thin out the tick rate. When the counter steps past its all-ones value, the block emits a single-cycle reset request and restarts from the load value. Software keeps the system alive by writing a fresh value to a refresh register. That write copies the load value into the counter.

The timer can be started or stopped only by writing two magic words to a key register, in the right order. Every writable register passes through a synchronisation slot. A write raises that register's pending flag. The written value takes effect only after a fixed number of slow ticks, and at that moment the flag drops. Software polls the flags before and after each write.

Top module: `wdog_keyed`

## Requirements
- R1: After reset the counter, load, refresh and control registers read 0, no pending flag is set, the timer is stopped and `wdt_reset` is low.
- R2: The timer starts only when the key register takes effect with 0xBBBB and then, as the next key value to take effect, 0x4444. Only the low 16 bits are compared.
- R3: The timer stops only when the key register takes effect with 0xAAAA and then, as the next key value to take effect, 0x5555.
- R4: Any other key value, or a second word that does not complete the started pair, abandons the partial sequence without changing the run state. A new 0xBBBB or 0xAAAA begins a fresh pair.
- R5: A refresh value that takes effect and differs from the previous refresh value copies the load register into the counter. A repeated value leaves the counter untouched. Writing the load register alone never changes the counter.
- R6: While running, the counter rises by one per advance. While stopped, it holds its value except when a refresh reloads it.
- R7: Control register bit 5 enables the prescaler and bits 4:2 hold the prescale value p. With the prescaler enabled, the counter advances once per 2^p slow ticks. With it disabled, it advances on every slow tick. The prescaler phase restarts whenever a control value takes effect.
- R8: An advance from all-ones loads the counter from the load register and drives `wdt_reset` high for exactly one clock cycle. A reload by refresh in the same cycle takes precedence over the advance.
- R9: Pending register bits: bit 0 for control, bit 2 for load, bit 3 for refresh, bit 4 for key. A write sets its bit. The bit clears on the SYNC_TICKS-th slow tick after the write, and in that same cycle the value takes effect.
- R10: A write to a register whose pending bit is set is discarded.
- R11: The revision register returns REV_CODE (default 0x21) in its low byte. Writes to it are ignored.
- R12: Word addresses are 0 revision, 1 control, 2 load, 3 counter (read-only), 4 refresh, 5 key, 6 pending. The key register and address 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Slow tick strobe, one clock cycle per tick |
| bus_addr | input | ADDR_W (3) | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| wdt_reset | output | 1 | One-cycle reset request on counter overflow |

## Verification
The arming logic is driven with three kinds of key streams: well-formed pairs, lone second words, and pairs broken by a stray or competing first word. Comparing the results shows whether the block honours the order of the words or merely their presence. Refresh is tried with a new value and with a repeated one, which tells a reload on change apart from a reload on every write. Counting is measured over fixed windows with the prescaler off and at p=2, which separates a per-tick advance from a 2^p divide. An overflow run checks both the reload value and the width of the reset pulse. Writes issued while a register is still pending show whether the posted-write guard holds.

// File: rtl/wdog_keyed_pkg.sv
package wdog_keyed_pkg;
   localparam int NUM_SLOTS = 4;
   localparam int SL_CTRL   = 0;
   localparam int SL_LOAD   = 1;
   localparam int SL_TRIG   = 2;
   localparam int SL_KEY    = 3;

   localparam int ADR_REV   = 0;
   localparam int ADR_CTRL  = 1;
   localparam int ADR_LOAD  = 2;
   localparam int ADR_COUNT = 3;
   localparam int ADR_TRIG  = 4;
   localparam int ADR_KEY   = 5;
   localparam int ADR_PEND  = 6;

   localparam logic [15:0] KEY_ARM_A  = 16'hBBBB;
   localparam logic [15:0] KEY_ARM_B  = 16'h4444;
   localparam logic [15:0] KEY_SAFE_A = 16'hAAAA;
   localparam logic [15:0] KEY_SAFE_B = 16'h5555;

   typedef enum logic [1:0] {KS_IDLE, KS_ARM, KS_SAFE} key_state_e;

   // status bit owned by each sync slot
   function automatic int slot_pend_bit(input int s);
      case (s)
         SL_CTRL: return 0;
         SL_LOAD: return 2;
         SL_TRIG: return 3;
         default: return 4;
      endcase
   endfunction

   function automatic int slot_addr(input int s);
      case (s)
         SL_CTRL: return ADR_CTRL;
         SL_LOAD: return ADR_LOAD;
         SL_TRIG: return ADR_TRIG;
         default: return ADR_KEY;
      endcase
   endfunction
endpackage

// File: rtl/wdog_sync_slot.sv
module wdog_sync_slot #(
   parameter int DATA_W     = 32,
   parameter int SYNC_TICKS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_req,
   input  logic [DATA_W-1:0] wr_data,
   output logic              pending,
   output logic              apply,
   output logic [DATA_W-1:0] value
);
   localparam int SW = $clog2(SYNC_TICKS + 1);

   logic [SW-1:0] left_q;

   // posted write: captured now, takes effect on the last tick of the delay
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b0;
         left_q  <= '0;
         value   <= '0;
      end else if (wr_req && !pending) begin
         pending <= 1'b1;
         left_q  <= SW'(SYNC_TICKS);
         value   <= wr_data;
      end else if (pending && tick_en) begin
         left_q <= left_q - 1'b1;
         if (left_q == SW'(1)) pending <= 1'b0;
      end
   end

   assign apply = pending & tick_en & (left_q == SW'(1));
endmodule

// File: rtl/wdog_key_fsm.sv
module wdog_key_fsm
   import wdog_keyed_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        apply,
   input  logic [15:0] word,
   output logic        running
);
   key_state_e st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= KS_IDLE;
         running <= 1'b0;
      end else if (apply) begin
         if (st_q == KS_ARM && word == KEY_ARM_B) begin
            running <= 1'b1;
            st_q    <= KS_IDLE;
         end else if (st_q == KS_SAFE && word == KEY_SAFE_B) begin
            running <= 1'b0;
            st_q    <= KS_IDLE;
         end else if (word == KEY_ARM_A) begin
            st_q <= KS_ARM;
         end else if (word == KEY_SAFE_A) begin
            st_q <= KS_SAFE;
         end else begin
            st_q <= KS_IDLE;
         end
      end
   end
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
   parameter int PS_W   = 3,
   parameter bit ENABLE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick_en,
   input  logic            running,
   input  logic            clear,
   input  logic            pre_en,
   input  logic [PS_W-1:0] ps,
   output logic            step
);
   localparam int PC_W = (1 << PS_W) - 1;

   if (ENABLE) begin : g_div
      logic [PC_W-1:0] cnt_q;
      logic [PC_W-1:0] last;

      assign last = (PC_W'(1) << ps) - PC_W'(1);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 cnt_q <= '0;
         else if (clear)             cnt_q <= '0;
         else if (tick_en && running)
            cnt_q <= (pre_en && cnt_q != last) ? cnt_q + 1'b1 : '0;
      end

      assign step = tick_en & running & (!pre_en | (cnt_q == last));
   end else begin : g_flat
      logic unused_in;
      assign unused_in = ^{clk, rst_n, clear, pre_en, ps};
      assign step      = tick_en & running;
   end
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
   import wdog_keyed_pkg::*;
#(
   parameter int         DATA_W      = 32,
   parameter int         CNT_W       = 32,
   parameter int         ADDR_W      = 3,
   parameter int         PS_W        = 3,
   parameter int         SYNC_TICKS  = 2,
   parameter logic [7:0] REV_CODE    = 8'h21,
   parameter bit         PRESCALE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              wdt_reset
);
   localparam int PS_LSB = 2;
   localparam int EN_BIT = PS_LSB + PS_W;

   if (CNT_W > DATA_W || DATA_W < 16 || ADDR_W < 3 || SYNC_TICKS < 1 ||
       PS_W < 1 || PS_W > 5 || EN_BIT >= DATA_W) begin : g_bad_cfg
      $error("wdog_keyed: unsupported parameter set");
   end

   logic [NUM_SLOTS-1:0] slot_pend, slot_apply, slot_wr;
   logic [DATA_W-1:0]    slot_val [NUM_SLOTS];

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      assign slot_wr[i] = bus_we && (bus_addr == ADDR_W'(slot_addr(i)));
      wdog_sync_slot #(.DATA_W(DATA_W), .SYNC_TICKS(SYNC_TICKS)) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick_en (tick_en),
         .wr_req  (slot_wr[i]),
         .wr_data (bus_wdata),
         .pending (slot_pend[i]),
         .apply   (slot_apply[i]),
         .value   (slot_val[i])
      );
   end

   logic              running;
   logic              step;
   logic              pre_en_q;
   logic [PS_W-1:0]   ps_q;
   logic [CNT_W-1:0]  load_q;
   logic [CNT_W-1:0]  count_q;
   logic [DATA_W-1:0] trig_q;
   logic              trig_reload;
   logic [4:0]        pend_flags;
   logic              unused_bits;

   assign unused_bits = ^{slot_val[SL_CTRL], slot_val[SL_KEY], slot_val[SL_LOAD]};

   wdog_key_fsm u_key (
      .clk     (clk),
      .rst_n   (rst_n),
      .apply   (slot_apply[SL_KEY]),
      .word    (slot_val[SL_KEY][15:0]),
      .running (running)
   );

   wdog_prescaler #(.PS_W(PS_W), .ENABLE(PRESCALE_EN)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .running (running),
      .clear   (slot_apply[SL_CTRL]),
      .pre_en  (pre_en_q),
      .ps      (ps_q),
      .step    (step)
   );

   assign trig_reload = slot_apply[SL_TRIG] && (slot_val[SL_TRIG] != trig_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_en_q  <= 1'b0;
         ps_q      <= '0;
         load_q    <= '0;
         trig_q    <= '0;
         count_q   <= '0;
         wdt_reset <= 1'b0;
      end else begin
         wdt_reset <= 1'b0;
         if (slot_apply[SL_CTRL]) begin
            pre_en_q <= slot_val[SL_CTRL][EN_BIT];
            ps_q     <= slot_val[SL_CTRL][PS_LSB +: PS_W];
         end
         if (slot_apply[SL_LOAD]) load_q <= slot_val[SL_LOAD][CNT_W-1:0];
         if (slot_apply[SL_TRIG]) trig_q <= slot_val[SL_TRIG];
         if (trig_reload) begin
            count_q <= load_q;
         end else if (step) begin
            if (&count_q) begin
               count_q   <= load_q;
               wdt_reset <= 1'b1;
            end else begin
               count_q <= count_q + 1'b1;
            end
         end
      end
   end

   always_comb begin
      pend_flags = '0;
      for (int i = 0; i < NUM_SLOTS; i++) pend_flags[slot_pend_bit(i)] = slot_pend[i];
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(ADR_REV):   bus_rdata[7:0] = REV_CODE;
         ADDR_W'(ADR_CTRL):  begin
            bus_rdata[EN_BIT]          = pre_en_q;
            bus_rdata[PS_LSB +: PS_W] = ps_q;
         end
         ADDR_W'(ADR_LOAD):  bus_rdata = DATA_W'(load_q);
         ADDR_W'(ADR_COUNT): bus_rdata = DATA_W'(count_q);
         ADDR_W'(ADR_TRIG):  bus_rdata = trig_q;
         ADDR_W'(ADR_PEND):  bus_rdata = DATA_W'(pend_flags);
         default:            bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk #(
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wdt_reset,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              running,
   input logic              key_apply,
   input logic [15:0]       key_word,
   input logic [3:0]        slot_pend,
   input logic              trig_apply,
   input logic [CNT_W-1:0]  count_q,
   input logic [CNT_W-1:0]  load_q
);
   a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_reset |=> !wdt_reset);

   a_r8_pulse_reload: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_reset |-> count_q == $past(load_q));

   a_r2_start_keyed: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running) |-> ($past(key_apply) && $past(key_word) == 16'h4444));

   a_r3_stop_keyed: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(running) |-> ($past(key_apply) && $past(key_word) == 16'h5555));

   a_r9_key_pend_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(5) && !slot_pend[3]) |=> slot_pend[3]);

   a_r6_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !trig_apply) |=> $stable(count_q));
endmodule

bind wdog_keyed wdog_keyed_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wdt_reset  (wdt_reset),
   .bus_we     (bus_we),
   .bus_addr   (bus_addr),
   .running    (running),
   .key_apply  (slot_apply[wdog_keyed_pkg::SL_KEY]),
   .key_word   (slot_val[wdog_keyed_pkg::SL_KEY][15:0]),
   .slot_pend  (slot_pend),
   .trig_apply (slot_apply[wdog_keyed_pkg::SL_TRIG]),
   .count_q    (count_q),
   .load_q     (load_q)
);

// File: tb/wdog_keyed_test.sv
module wdog_keyed_test;
   localparam int SYNC = 2;
   localparam int TDIV = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        bus_we = 1'b0;
   logic [2:0]  bus_addr = 3'd0;
   logic [31:0] bus_wdata = 32'd0;
   logic [31:0] bus_rdata;
   logic        wdt_reset;

   always #4 clk = ~clk;

   wdog_keyed #(.SYNC_TICKS(SYNC)) uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
      .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .wdt_reset(wdt_reset)
   );

   int total = 0;
   int bad   = 0;
   int cyc   = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      #2 tick_en = (cyc % TDIV) == 0;
   end

   always @(posedge clk) begin
      if (cyc == 150000) begin
         bad++;
         total++;
         $display("FAIL watchdog expired (R1..R12 incomplete)");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // ---------------- behavioural reference model ----------------
   bit          m_pend [4];
   int          m_left [4];
   logic [31:0] m_shad [4];
   bit          m_pre, m_run, m_pulse;
   int          m_ps, m_ks, m_div;
   logic [31:0] m_load, m_trig, m_count;
   const int    slot_adr [4] = '{1, 2, 4, 5};

   always @(posedge clk) begin
      bit ap [4];
      bit stp, rel;
      int lastv;
      logic [15:0] w;
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) begin m_pend[i] = 0; m_left[i] = 0; m_shad[i] = 0; end
         m_pre = 0; m_run = 0; m_pulse = 0; m_ps = 0; m_ks = 0; m_div = 0;
         m_load = 0; m_trig = 0; m_count = 0;
      end else begin
         for (int i = 0; i < 4; i++) ap[i] = m_pend[i] && tick_en && m_left[i] == 1;
         lastv = (1 << m_ps) - 1;
         stp = m_run && tick_en && (!m_pre || m_div == lastv);
         rel = ap[2] && (m_shad[2] != m_trig);
         m_pulse = 0;
         if (rel) m_count = m_load;
         else if (stp) begin
            if (m_count == 32'hFFFF_FFFF) begin m_count = m_load; m_pulse = 1; end
            else m_count = m_count + 1;
         end
         if (ap[0]) m_div = 0;
         else if (tick_en && m_run) m_div = (m_pre && m_div != lastv) ? m_div + 1 : 0;
         if (ap[3]) begin
            w = m_shad[3][15:0];
            if (m_ks == 1 && w == 16'h4444) begin m_run = 1; m_ks = 0; end
            else if (m_ks == 2 && w == 16'h5555) begin m_run = 0; m_ks = 0; end
            else m_ks = (w == 16'hBBBB) ? 1 : (w == 16'hAAAA) ? 2 : 0;
         end
         if (ap[0]) begin m_pre = m_shad[0][5]; m_ps = int'(m_shad[0][4:2]); end
         if (ap[1]) m_load = m_shad[1];
         if (ap[2]) m_trig = m_shad[2];
         for (int i = 0; i < 4; i++) begin
            if (bus_we && int'(bus_addr) == slot_adr[i] && !m_pend[i]) begin
               m_shad[i] = bus_wdata; m_left[i] = SYNC; m_pend[i] = 1;
            end else if (m_pend[i] && tick_en) begin
               if (m_left[i] == 1) m_pend[i] = 0;
               m_left[i] = m_left[i] - 1;
            end
         end
      end
   end

   function automatic logic [31:0] m_read(input logic [2:0] a);
      case (a)
         3'd0: return 32'h21;
         3'd1: return {26'd0, m_pre, 3'(m_ps), 2'b00};
         3'd2: return m_load;
         3'd3: return m_count;
         3'd4: return m_trig;
         3'd6: return {27'd0, m_pend[3], m_pend[2], m_pend[1], 1'b0, m_pend[0]};
         default: return 32'd0;
      endcase
   endfunction

   function automatic string tag_of(input logic [2:0] a);
      case (a)
         3'd0: return "R11";
         3'd1: return "R7";
         3'd2: return "R10";
         3'd3: return "R6";
         3'd4: return "R5";
         3'd6: return "R9";
         default: return "R12";
      endcase
   endfunction

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R8", {31'd0, wdt_reset}, {31'd0, m_pulse});
         chk(tag_of(bus_addr), bus_rdata, m_read(bus_addr));
      end
   end

   // ---------------- directed stimulus ----------------
   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(posedge clk); #2 bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #2 bus_we = 1'b0;
   endtask

   task automatic settle();
      @(posedge clk); #2 bus_addr = 3'd6;
      do @(negedge clk); while (bus_rdata != 32'd0);
   endtask

   task automatic wrs(input logic [2:0] a, input logic [31:0] d);
      wr(a, d);
      settle();
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] v);
      @(posedge clk); #2 bus_addr = a;
      @(negedge clk); v = bus_rdata;
   endtask

   initial begin
      logic [31:0] v, v2;
      int d;
      bit seen;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", {31'd0, wdt_reset}, 32'd0);
      chk("R11", bus_rdata, 32'h21);
      @(posedge clk); #2 rst_n = 1'b1;

      rd(3'd6, v); chk("R1", v, 32'd0);
      rd(3'd3, v); chk("R1", v, 32'd0);
      rd(3'd1, v); chk("R1", v, 32'd0);
      wr(3'd0, 32'hFFFF_FFFF);
      rd(3'd0, v); chk("R11", v, 32'h21);

      // posted write and discard while pending
      wr(3'd2, 32'hFFFF_FF00);
      rd(3'd6, v); chk("R9", v, 32'h04);
      wr(3'd2, 32'h0000_1234);
      settle();
      rd(3'd2, v); chk("R10", v, 32'hFFFF_FF00);
      rd(3'd3, v); chk("R5", v, 32'd0);
      wrs(3'd4, 32'd1);
      rd(3'd3, v); chk("R5", v, 32'hFFFF_FF00);

      // broken start sequences
      wrs(3'd5, 32'h4444); wrs(3'd5, 32'hBBBB); wrs(3'd5, 32'h1234); wrs(3'd5, 32'h4444);
      repeat (40) @(posedge clk);
      rd(3'd3, v); chk("R4", v, 32'hFFFF_FF00);
      wrs(3'd5, 32'hBBBB); wrs(3'd5, 32'hAAAA); wrs(3'd5, 32'h4444);
      repeat (40) @(posedge clk);
      rd(3'd3, v); chk("R4", v, 32'hFFFF_FF00);
      rd(3'd5, v); chk("R12", v, 32'd0);
      rd(3'd7, v); chk("R12", v, 32'd0);

      // proper start
      wrs(3'd5, 32'hBBBB); wrs(3'd5, 32'h4444);
      rd(3'd3, v); repeat (40) @(posedge clk); rd(3'd3, v2);
      d = int'(v2 - v);
      chk("R2", {31'd0, d > 0}, 32'd1);
      chk("R6", {31'd0, d >= 9 && d <= 12}, 32'd1);

      // broken stop sequence keeps running
      wrs(3'd5, 32'hAAAA); wrs(3'd5, 32'hBBBB); wrs(3'd5, 32'h5555);
      rd(3'd3, v); repeat (40) @(posedge clk); rd(3'd3, v2);
      chk("R4", {31'd0, v2 != v}, 32'd1);

      // proper stop
      wrs(3'd5, 32'hAAAA); wrs(3'd5, 32'h5555);
      rd(3'd3, v); repeat (40) @(posedge clk); rd(3'd3, v2);
      chk("R3", v2, v);

      // repeated refresh value has no effect
      wrs(3'd2, 32'hFFFF_FFF0);
      wrs(3'd4, 32'd1);
      rd(3'd3, v2); chk("R5", v2, v);
      wrs(3'd4, 32'd2);
      rd(3'd3, v2); chk("R5", v2, 32'hFFFF_FFF0);

      // prescaler p=2
      wrs(3'd1, 32'h28);
      rd(3'd1, v); chk("R7", v, 32'h28);
      wrs(3'd2, 32'h0000_1000); wrs(3'd4, 32'd3);
      wrs(3'd5, 32'hBBBB); wrs(3'd5, 32'h4444);
      rd(3'd3, v); repeat (128) @(posedge clk); rd(3'd3, v2);
      d = int'(v2 - v);
      chk("R7", {31'd0, d >= 7 && d <= 9}, 32'd1);
      wrs(3'd5, 32'hAAAA); wrs(3'd5, 32'h5555);

      // prescaler off
      wrs(3'd1, 32'h0C);
      wrs(3'd5, 32'hBBBB); wrs(3'd5, 32'h4444);
      rd(3'd3, v); repeat (64) @(posedge clk); rd(3'd3, v2);
      d = int'(v2 - v);
      chk("R7", {31'd0, d >= 15 && d <= 18}, 32'd1);

      // overflow
      wrs(3'd2, 32'hFFFF_FFF0); wrs(3'd4, 32'd4);
      @(posedge clk); #2 bus_addr = 3'd3;
      seen = 0;
      for (int k = 0; k < 400 && !seen; k++) begin
         @(negedge clk);
         if (wdt_reset) seen = 1;
      end
      chk("R8", {31'd0, seen}, 32'd1);
      chk("R8", bus_rdata, 32'hFFFF_FFF0);
      @(negedge clk);
      chk("R8", {31'd0, wdt_reset}, 32'd0);

      repeat (10) @(posedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule